// File: doc/BRIEF.md
# Ping-Pong Insertion Sorter for Request Packets

This block sits between a group of processors and a routing network. The processors hand it request packets over one input port, one packet per cycle at most. Each packet has a destination key and a payload. The block collects a fixed-size part of a round in one sorting array. It then emits that part on its output in ascending key order, one packet per cycle. Each cell of an array holds one packet. A new packet is placed directly at its sorted position: every stored entry with a larger key moves one cell further along.

There are two arrays, and their roles alternate. One array takes new packets while the other shifts its sorted contents out. The roles swap as soon as both of these hold:
- the filling array is closed, because it is full or because it took an end-of-round marker;
- the draining array has at most its last entry left.

With this rule the output can stream parts back to back. The end-of-round marker always sorts behind every real packet of its part, whatever its key field holds. This lets the network downstream separate rounds. The asynchronous active-low reset is released to the logic through a two-stage synchronizer.

Top module: `sys_sort_pingpong`

## Requirements
- R1: After reset, out_valid is 0 and stays 0 while no packet has been accepted.
- R2: Within one part, packets leave in non-decreasing order of the composite value {in_eor, in_key}. Packets with equal composite values leave in the order they were accepted.
- R3: A packet with in_eor=1 is stored with its key field unchanged. It orders after every real packet of its part, whatever its key. It is emitted with out_eor=1, and it closes the part it belongs to.
- R4: A part closes when its DEPTH-th packet is accepted. An end-of-round packet counts as one of the DEPTH.
- R5: A closed part changes roles at the clock edge where the draining array holds at most one entry. If the draining array is already empty, this is the same edge that accepts the closing packet, and the part's smallest packet appears on the outputs in the next cycle.
- R6: A draining array presents one packet per cycle, with no gaps, until it is empty. No accepted packet is lost or duplicated.
- R7: While the filling array is closed and waiting for the swap, packets presented with in_valid=1 are ignored and never appear on the outputs.
- R8: Packets presented while the other array drains are accepted in the same cycle, without stalling.
- R9: A part closed early by an end-of-round packet emits only the packets it accepted, followed by no empty entries.
- R10: Cycles with in_valid=0 change nothing in the filling array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A packet is presented this cycle |
| in_eor | input | 1 | The presented packet is the end-of-round marker |
| in_key | input | KEY_W | Destination key of the presented packet |
| in_data | input | DATA_W | Payload of the presented packet |
| out_valid | output | 1 | An emitted packet is present |
| out_eor | output | 1 | The emitted packet is an end-of-round marker |
| out_key | output | KEY_W | Key of the emitted packet |
| out_data | output | DATA_W | Payload of the emitted packet |

## Verification
The assertions check the following on every cycle:
- within one part, output keys never decrease;
- nothing is emitted after a marker before the roles swap;
- a closed array takes no packets;
- a swap never happens while the draining array holds two or more entries;
- no array is inserted into and shifted in the same cycle;
- the fill count stays at or below the array depth.

Only the bench scenarios can show the following:
- that equal keys keep their arrival order;
- the exact cycle in which a part first appears on the outputs;
- that packets presented during a wait are dropped rather than stored;
- that every accepted packet comes out exactly once.

// File: rtl/sort_pp_pkg.sv
package sort_pp_pkg;
  typedef enum logic {ARR_A = 1'b0, ARR_B = 1'b1} arr_sel_e;

  function automatic arr_sel_e other_arr(input arr_sel_e s);
    return (s == ARR_A) ? ARR_B : ARR_A;
  endfunction
endpackage

// File: rtl/sort_rst_sync.sv
module sort_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/sort_cell.sv
// One storage cell of an insertion array.
// Entry layout: [W-1] valid, [W-2] eor, then key, then data.
module sort_cell #(
  parameter int KEY_W  = 8,
  parameter int DATA_W = 8,
  localparam int W     = 2 + KEY_W + DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ins,      // broadcast insertion this cycle
  input  logic         shf,      // shift toward the head this cycle
  input  logic         left_gt,  // neighbour closer to the head yields its place
  input  logic [W-1:0] left_e,
  input  logic [W-1:0] right_e,
  input  logic [W-1:0] new_e,
  output logic [W-1:0] cur_e,
  output logic         gt
);
  logic [W-1:0] cur_q, cur_d;
  logic         en;

  // A cell yields its place when it is empty, or when its {eor,key} is
  // strictly larger than the new one. Equal values stay in front (stable order).
  assign gt = ~cur_q[W-1] | (cur_q[W-2:DATA_W] > new_e[W-2:DATA_W]);
  assign en = ins | shf;

  always_comb begin
    cur_d = cur_q;
    if (shf) begin
      cur_d = right_e;
    end else if (ins && gt) begin
      if (left_gt) cur_d = left_e;   // pushed one place further along
      else         cur_d = new_e;    // this cell is the insertion point
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cur_q <= '0;
    else if (en) cur_q <= cur_d;
  end

  assign cur_e = cur_q;
endmodule

// File: rtl/sort_row.sv
module sort_row #(
  parameter int DEPTH  = 8,
  parameter int KEY_W  = 8,
  parameter int DATA_W = 8,
  localparam int W     = 2 + KEY_W + DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ins,
  input  logic         shf,
  input  logic [W-1:0] new_e,
  output logic [W-1:0] head_e,
  output logic         second_v
);
  logic [W-1:0] ent [DEPTH];
  logic         gt  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [W-1:0] l_e, r_e;
    logic         l_gt;

    if (i == 0) begin : g_first
      assign l_e  = '0;
      assign l_gt = 1'b0;
    end else begin : g_mid
      assign l_e  = ent[i-1];
      assign l_gt = gt[i-1];
    end

    if (i == DEPTH - 1) begin : g_last
      assign r_e = '0;
    end else begin : g_inner
      assign r_e = ent[i+1];
    end

    sort_cell #(.KEY_W(KEY_W), .DATA_W(DATA_W)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .ins    (ins),
      .shf    (shf),
      .left_gt(l_gt),
      .left_e (l_e),
      .right_e(r_e),
      .new_e  (new_e),
      .cur_e  (ent[i]),
      .gt     (gt[i])
    );
  end

  assign head_e   = ent[0];
  assign second_v = ent[1][W-1];
endmodule

// File: rtl/sort_pp_ctrl.sv
module sort_pp_ctrl
  import sort_pp_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_eor,
  input  logic          drain_v1,
  output logic          accept,
  output logic          swap,
  output logic          closed,
  output arr_sel_e      sel,
  output logic [CW-1:0] cnt
);
  arr_sel_e      sel_q, sel_d;
  logic          closed_q, closed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  always_comb begin
    accept   = in_valid & ~closed_q;
    last     = accept & (in_eor | (cnt_q == CW'(DEPTH - 1)));
    swap     = (closed_q | last) & ~drain_v1;
    sel_d    = swap ? other_arr(sel_q) : sel_q;
    closed_d = swap ? 1'b0 : (closed_q | last);
    cnt_d    = swap ? '0 : (cnt_q + CW'(accept));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= ARR_A;
      closed_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sel_q    <= sel_d;
      closed_q <= closed_d;
      cnt_q    <= cnt_d;
    end
  end

  assign sel    = sel_q;
  assign closed = closed_q;
  assign cnt    = cnt_q;
endmodule

// File: rtl/sys_sort_pingpong.sv
module sys_sort_pingpong
  import sort_pp_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int KEY_W  = 8,
  parameter int DATA_W = 8,
  localparam int W     = 2 + KEY_W + DATA_W,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_eor,
  input  logic [KEY_W-1:0]  in_key,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_eor,
  output logic [KEY_W-1:0]  out_key,
  output logic [DATA_W-1:0] out_data
);
  logic          rst_n_i;
  logic          accept, swap, closed, drain_v1;
  arr_sel_e      sel;
  logic [CW-1:0] cnt;
  logic [W-1:0]  new_e, drain_e;
  logic [W-1:0]  head [2];
  logic          v1   [2];
  logic          ins  [2];
  logic          shf  [2];

  sort_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  sort_pp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .in_valid(in_valid),
    .in_eor  (in_eor),
    .drain_v1(drain_v1),
    .accept  (accept),
    .swap    (swap),
    .closed  (closed),
    .sel     (sel),
    .cnt     (cnt)
  );

  assign new_e = {1'b1, in_eor, in_key, in_data};

  for (genvar g = 0; g < 2; g++) begin : g_arr
    assign ins[g] = accept & (sel == arr_sel_e'(g));
    assign shf[g] = (sel != arr_sel_e'(g));

    sort_row #(.DEPTH(DEPTH), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_row (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .ins     (ins[g]),
      .shf     (shf[g]),
      .new_e   (new_e),
      .head_e  (head[g]),
      .second_v(v1[g])
    );
  end

  // The draining array is always the one not selected for filling.
  assign drain_e  = (sel == ARR_A) ? head[1] : head[0];
  assign drain_v1 = (sel == ARR_A) ? v1[1]   : v1[0];

  assign out_valid = drain_e[W-1];
  assign out_eor   = drain_e[W-2];
  assign out_key   = drain_e[W-3 -: KEY_W];
  assign out_data  = drain_e[DATA_W-1:0];
endmodule

// File: rtl/sort_pp_checker.sv
module sort_pp_checker #(
  parameter int DEPTH = 8,
  parameter int KEY_W = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_eor,
  input logic [KEY_W-1:0] out_key,
  input logic             accept,
  input logic             closed,
  input logic             swap,
  input logic             drain_v1,
  input logic             sel,
  input logic [CW-1:0]    cnt,
  input logic             ins_a,
  input logic             shf_a,
  input logic             ins_b,
  input logic             shf_b
);
  p_sorted_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) && (sel == $past(sel)))
      |-> ({out_eor, out_key} >= $past({out_eor, out_key})));

  p_marker_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eor) |=> (!out_valid || (sel != $past(sel))));

  p_full_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= CW'(DEPTH)) && ((cnt == CW'(DEPTH)) -> closed));

  p_swap_when_drained_r5: assert property (@(posedge clk) disable iff (!rst_n)
    swap |-> !drain_v1);

  p_closed_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
    closed |-> !accept);

  p_role_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_a && shf_a) && !(ins_b && shf_b));
endmodule

bind sys_sort_pingpong sort_pp_checker #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .out_valid(out_valid),
  .out_eor  (out_eor),
  .out_key  (out_key),
  .accept   (accept),
  .closed   (closed),
  .swap     (swap),
  .drain_v1 (drain_v1),
  .sel      (sel),
  .cnt      (cnt),
  .ins_a    (ins[0]),
  .shf_a    (shf[0]),
  .ins_b    (ins[1]),
  .shf_b    (shf[1])
);

// File: tb/sim_sys_sort_pingpong.sv
module sim_sys_sort_pingpong;
  localparam int CLK_PERIOD = 10;
  localparam int DEP = 8;
  localparam int KW  = 8;
  localparam int DW  = 8;
  localparam int EW  = 1 + KW + DW;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_eor = 1'b0;
  logic [KW-1:0] in_key = '0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid, out_eor;
  logic [KW-1:0] out_key;
  logic [DW-1:0] out_data;

  int n_tests = 0, n_fail = 0;
  int n_acc = 0, n_acc_eor = 0, n_out = 0, n_out_eor = 0;
  bit marker_seen = 1'b0;
  bit run_cmp = 1'b0;
  string cur_req = "R1";

  // Behavioural reference: a sorted queue per role and a closed flag.
  logic [EW-1:0] fq[$];
  logic [EW-1:0] dq[$];
  bit m_closed = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_sort_pingpong #(.DEPTH(DEP), .KEY_W(KW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eor(in_eor),
    .in_key(in_key), .in_data(in_data), .out_valid(out_valid),
    .out_eor(out_eor), .out_key(out_key), .out_data(out_data)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      fq.delete(); dq.delete(); m_closed = 1'b0;
    end else begin
      bit acc, lst, sw;
      logic [EW-1:0] ent;
      int pos;
      acc = in_valid && !m_closed;
      lst = acc && (in_eor || fq.size() == DEP - 1);
      sw  = (m_closed || lst) && dq.size() <= 1;
      if (dq.size() > 0) void'(dq.pop_front());
      if (acc) begin
        ent = {in_eor, in_key, in_data};
        pos = fq.size();
        for (int j = fq.size() - 1; j >= 0; j--)
          if (fq[j][EW-1:DW] > ent[EW-1:DW]) pos = j;
        fq.insert(pos, ent);
        n_acc++;
        if (in_eor) n_acc_eor++;
      end
      if (sw) begin
        dq = fq; fq.delete(); m_closed = 1'b0;
      end else begin
        m_closed = m_closed || lst;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (run_cmp) begin
      bit ev;
      ev = dq.size() > 0;
      check(out_valid == ev, cur_req, "out_valid", out_valid, ev);
      if (ev && out_valid) begin
        check({out_eor, out_key, out_data} == dq[0], cur_req, "packet",
              {out_eor, out_key, out_data}, dq[0]);
      end
      if (out_valid) begin
        n_out++;
        if (out_eor) n_out_eor++;
        if (out_data == 8'hEE) marker_seen = 1'b1;
      end
    end
  end

  task automatic send(input bit eor, input logic [KW-1:0] k, input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_eor = eor; in_key = k; in_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_eor = 1'b0;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    run_cmp = 1'b1;

    // R4 and R2: full part with descending keys, then R8/R5: next part back to back.
    cur_req = "R4";
    for (int i = 0; i < DEP; i++) send(1'b0, KW'(200 - 10 * i), DW'(i));
    cur_req = "R8";
    for (int i = 0; i < DEP; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(1'b0, lfsr[7:0], DW'(16 + i));
    end
    idle(2 * DEP + 4);

    // R2 ties keep arrival order; R3/R9 early marker with key 0.
    cur_req = "R2";
    send(1'b0, 8'd5, 8'h31); send(1'b0, 8'd3, 8'h32); send(1'b0, 8'd5, 8'h33);
    send(1'b0, 8'd3, 8'h34); send(1'b0, 8'd5, 8'h35);
    cur_req = "R3";
    send(1'b1, 8'd0, 8'h36);
    idle(DEP + 4);

    // R5: swap on the closing edge when drain is empty; first packet the next cycle.
    cur_req = "R5";
    send(1'b0, 8'd9, 8'h41);
    send(1'b1, 8'd0, 8'h42);
    @(negedge clk); in_valid = 1'b0; in_eor = 1'b0;
    check(out_valid && out_key == 8'd9 && out_data == 8'h41, "R5",
          "first packet one cycle after closing", {out_key, out_data}, 16'h0941);
    idle(DEP);

    // R7: full part, then a tiny closed part that waits; markers presented meanwhile.
    cur_req = "R7";
    for (int i = 0; i < DEP; i++) send(1'b0, KW'(i * 7), DW'(64 + i));
    send(1'b0, 8'd1, 8'h50);
    send(1'b1, 8'd2, 8'h51);
    for (int i = 0; i < 4; i++) send(1'b0, 8'd0, 8'hEE);
    idle(3 * DEP);
    check(marker_seen == 1'b0, "R7", "ignored packet emitted", marker_seen, 0);

    // R10: sparse injection with gaps.
    cur_req = "R10";
    for (int i = 0; i < DEP; i++) begin
      send(1'b0, KW'(100 - i), DW'(80 + i));
      idle(i % 3);
    end
    idle(2 * DEP);

    // R6: random traffic with occasional markers.
    cur_req = "R6";
    for (int i = 0; i < 120; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[15:14] == 2'b00) idle(1);
      else send(lfsr[13:10] == 4'h0, lfsr[7:0], DW'(i & 8'h7F));
    end
    idle(3 * DEP + 4);

    check(n_out == n_acc, "R6", "emitted count", n_out, n_acc);
    check(n_out_eor == n_acc_eor, "R3", "marker count", n_out_eor, n_acc_eor);
    check(out_valid == 1'b0, "R10", "idle output", out_valid, 0);
    run_cmp = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule